// File: doc/BRIEF.md
# Operand Bus Master Sequencer

This block sits between a processor core and a shared operand (data) bus that other masters may also own. When the core asks for an operand read or write, the sequencer wins the bus with a request, grant and busy handshake, then claims it with a grant-acknowledge. Grant and busy are sampled on falling clock edges. The sequencer then runs one strobed transfer and reports completion back to the core. The instruction path is separate, and an instruction that needs no operand leaves every operand bus line idle.

The transfer drives the address and direction with an address strobe, and raises a data strobe half a clock later. It then holds everything until the addressed device returns a transfer acknowledge, so a slow device adds wait states simply by holding the acknowledge back. On the rising edge where the acknowledge is seen, the strobes and ownership drop together and read data is captured. The core then gets a single-cycle done pulse. The core side accepts a new request only while the sequencer is idle.

Top module: `opbus_master`

## Requirements
- R1: While reset is asserted, and immediately when it is asserted mid-transfer, bus_req, bus_gack, bus_as, bus_ds, bus_doe and core_done are low and bus_addr is zero.
- R2: A core_req raised while a transfer is in progress is ignored: no further bus request or done pulse follows it.
- R3: A request accepted on a rising edge raises bus_req at the following falling edge, not at the rising edge itself.
- R4: bus_gack rises on the first rising edge after a falling edge at which bus_grant was high and bus_busy low; while busy is seen high it stays low.
- R5: bus_req is released at the falling edge that follows the rise of bus_gack.
- R6: bus_as, the address and the direction become valid on the rising edge that claims the bus; bus_ds follows at the next falling edge. bus_ds is never high without bus_as, and bus_as never without bus_gack.
- R7: The strobes stay asserted for every rising edge at which bus_ack is low, adding one wait cycle per such edge.
- R8: On the rising edge that samples bus_ack high, bus_as, bus_ds and bus_gack all fall, and on a read bus_din is captured into core_rdata. A write leaves core_rdata unchanged.
- R9: core_done is high for exactly the one cycle after the acknowledge edge.
- R10: bus_rd is 1 for a read and 0 for a write while the bus is owned. bus_doe is high, with bus_dout equal to the write data, only during an owned write.
- R11: bus_addr is zero whenever the bus is not owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; grant and busy are sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| core_req | input | 1 | Core operand request, taken only when idle |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | AW | Operand address |
| core_wdata | input | DW | Write data |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | DW | Read data captured on the acknowledge edge |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Grant from the arbiter |
| bus_busy | input | 1 | Previous owner still holds the bus |
| bus_gack | output | 1 | Grant acknowledge: this master owns the bus |
| bus_as | output | 1 | Address strobe |
| bus_ds | output | 1 | Data strobe |
| bus_rd | output | 1 | Direction, 1 = read, valid while owned |
| bus_addr | output | AW | Operand address, zero when not owned |
| bus_dout | output | DW | Write data driven onto the bus |
| bus_doe | output | 1 | Output enable for bus_dout |
| bus_din | input | DW | Read data from the bus |
| bus_ack | input | 1 | Transfer acknowledge; withholding it adds wait states |

## Verification
The collision of interest is a fresh core request landing in the same cycles as an ongoing transfer's wait states and acknowledge. The bench raises core_req during the wait states of a read with a different address. It judges the result at the ports: exactly one done pulse follows, and bus_req stays low for several falling edges after that pulse. A second overlap, the grant arriving while busy is still high, is exercised by varying the busy release time and checking the exact claim edge.

// File: rtl/opbus_pkg.sv
package opbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_ADDR = 2'd2,
    ST_XFER = 2'd3
  } opbus_state_e;
endpackage

// File: rtl/opbus_rst_sync.sv
module opbus_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/opbus_fall_sampler.sv
module opbus_fall_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_grant,
  input  logic bus_busy,
  input  logic arb_active,
  input  logic own_active,
  output logic grant_s,
  output logic busy_s,
  output logic req_q,
  output logic ds_q
);
  logic grant_d, busy_d, req_d, ds_d;

  always_comb begin
    grant_d = bus_grant;
    busy_d  = bus_busy;
    req_d   = arb_active;
    ds_d    = own_active;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_s <= 1'b0;
      busy_s  <= 1'b1;
      req_q   <= 1'b0;
      ds_q    <= 1'b0;
    end else begin
      grant_s <= grant_d;
      busy_s  <= busy_d;
      req_q   <= req_d;
      ds_q    <= ds_d;
    end
  end
endmodule

// File: rtl/opbus_seq.sv
module opbus_seq
  import opbus_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_req,
  input  logic          core_we,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  input  logic          grant_s,
  input  logic          busy_s,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_din,
  output opbus_state_e  state_q,
  output logic          we_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          done_q,
  output logic [DW-1:0] rdata_q
);
  opbus_state_e state_d;
  logic load_en, ack_hit, rdata_en, done_d;

  always_comb begin
    state_d  = state_q;
    load_en  = 1'b0;
    ack_hit  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (core_req) begin
        load_en = 1'b1;
        state_d = ST_ARB;
      end
      ST_ARB:  if (grant_s && !busy_s) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_XFER;
      ST_XFER: if (bus_ack) begin
        ack_hit = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    rdata_en = ack_hit && !we_q;
    done_d   = ack_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (load_en) we_q <= core_we;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      addr_q  <= core_addr;
      wdata_q <= core_wdata;
    end
    if (rdata_en) rdata_q <= bus_din;
  end
endmodule

// File: rtl/opbus_drive.sv
module opbus_drive
  import opbus_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16
) (
  input  opbus_state_e  state_q,
  input  logic          we_q,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] wdata_q,
  input  logic          ds_q,
  output logic          own,
  output logic          bus_gack,
  output logic          bus_as,
  output logic          bus_ds,
  output logic          bus_rd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe
);
  localparam logic [AW-1:0] ADDR_IDLE = '0;
  localparam logic [DW-1:0] DATA_IDLE = '0;

  always_comb begin
    own      = (state_q == ST_ADDR) || (state_q == ST_XFER);
    bus_gack = own;
    bus_as   = own;
    bus_ds   = own && ds_q;
    bus_rd   = own && !we_q;
    bus_doe  = own && we_q;
    bus_addr = own ? addr_q : ADDR_IDLE;
    bus_dout = bus_doe ? wdata_q : DATA_IDLE;
  end
endmodule

// File: rtl/opbus_master.sv
module opbus_master
  import opbus_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_req,
  input  logic          core_we,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic          core_done,
  output logic [DW-1:0] core_rdata,
  output logic          bus_req,
  input  logic          bus_grant,
  input  logic          bus_busy,
  output logic          bus_gack,
  output logic          bus_as,
  output logic          bus_ds,
  output logic          bus_rd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_ack
);
  logic         rst_sync_n;
  opbus_state_e state_q;
  logic         we_q, grant_s, busy_s, ds_q, own;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  opbus_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_sync(rst_sync_n)
  );

  opbus_fall_sampler u_fall (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_grant(bus_grant), .bus_busy(bus_busy),
    .arb_active(state_q == ST_ARB), .own_active(own),
    .grant_s(grant_s), .busy_s(busy_s), .req_q(bus_req), .ds_q(ds_q)
  );

  opbus_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
    .core_wdata(core_wdata), .grant_s(grant_s), .busy_s(busy_s),
    .bus_ack(bus_ack), .bus_din(bus_din),
    .state_q(state_q), .we_q(we_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .done_q(core_done), .rdata_q(core_rdata)
  );

  opbus_drive #(.AW(AW), .DW(DW)) u_drv (
    .state_q(state_q), .we_q(we_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .ds_q(ds_q), .own(own), .bus_gack(bus_gack), .bus_as(bus_as),
    .bus_ds(bus_ds), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_doe(bus_doe)
  );
endmodule

// File: rtl/opbus_master_chk.sv
module opbus_master_chk #(
  parameter int unsigned AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_done,
  input logic          bus_req,
  input logic          bus_gack,
  input logic          bus_as,
  input logic          bus_ds,
  input logic          bus_rd,
  input logic          bus_doe,
  input logic          bus_ack,
  input logic [AW-1:0] bus_addr
);
  AST_GACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_gack) |-> $past(bus_req)); // R4
  AST_REQ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_gack) |=> !bus_req); // R5
  AST_DS_IN_AS: assert property (@(posedge clk) disable iff (!rst_n) bus_ds |-> bus_as); // R6
  AST_AS_OWNED: assert property (@(posedge clk) disable iff (!rst_n) bus_as |-> bus_gack); // R6
  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (bus_ds && !bus_ack) |=> bus_as); // R7
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) core_done |-> (!bus_as && !bus_ds && !bus_gack)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) core_done |=> !core_done); // R9
  AST_OE_WRITE_OWNED: assert property (@(posedge clk) disable iff (!rst_n) bus_doe |-> (bus_gack && !bus_rd)); // R10
  AST_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !bus_gack |-> (bus_addr == '0)); // R11
endmodule

bind opbus_master opbus_master_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_done(core_done), .bus_req(bus_req),
  .bus_gack(bus_gack), .bus_as(bus_as), .bus_ds(bus_ds), .bus_rd(bus_rd),
  .bus_doe(bus_doe), .bus_ack(bus_ack), .bus_addr(bus_addr)
);

// File: tb/opbus_master_tb.sv
module opbus_master_tb;
  localparam int AW = 20;
  localparam int DW = 16;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdat;
    logic [3:0]    busy;
    logic [3:0]    waits;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 20'h00010, 16'h0000, 16'hA5C3, 4'd0, 4'd0},
    '{1'b1, 20'hFFFFF, 16'h1234, 16'h0000, 4'd0, 4'd0},
    '{1'b0, 20'h80001, 16'h0000, 16'h5A0F, 4'd3, 4'd2},
    '{1'b1, 20'h0ABCD, 16'hBEEF, 16'hFFFF, 4'd1, 4'd5},
    '{1'b0, 20'h00001, 16'h0000, 16'hFFFF, 4'd0, 4'd7},
    '{1'b1, 20'h7F00F, 16'h0F0F, 16'h1111, 4'd5, 4'd1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic core_req, core_we, core_done;
  logic [AW-1:0] core_addr, bus_addr;
  logic [DW-1:0] core_wdata, core_rdata, bus_dout, bus_din;
  logic bus_req, bus_grant, bus_busy, bus_gack, bus_as, bus_ds, bus_rd, bus_doe, bus_ack;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] exp_rdata;

  always #2 clk = ~clk;

  opbus_master #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_done(core_done),
    .core_rdata(core_rdata), .bus_req(bus_req), .bus_grant(bus_grant),
    .bus_busy(bus_busy), .bus_gack(bus_gack), .bus_as(bus_as), .bus_ds(bus_ds),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .bus_ack(bus_ack)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_outputs(input string req);
    chk(req, {31'd0, bus_req}, 0);
    chk(req, {31'd0, bus_gack}, 0);
    chk(req, {30'd0, bus_as, bus_ds}, 0);
    chk(req, {31'd0, bus_doe}, 0);
    chk(req, {31'd0, core_done}, 0);
    chk(req, {12'd0, bus_addr}, 0);
  endtask

  task automatic txn(input vec_t v, input bit poke);
    @(posedge clk); #1;
    core_req = 1'b1; core_we = v.we; core_addr = v.addr; core_wdata = v.wdata;
    @(posedge clk); #1;
    core_req = 1'b0;
    chk("R3 no req at accept edge", {31'd0, bus_req}, 0);
    @(negedge clk); #1;
    chk("R3 req at falling edge", {31'd0, bus_req}, 1);
    bus_grant = 1'b1;
    bus_busy  = (v.busy != 0);
    for (int k = 1; k <= int'(v.busy) + 2; k++) begin
      @(posedge clk); #1;
      if (k == int'(v.busy) + 1) bus_busy = 1'b0;
      if (k < int'(v.busy) + 2) begin
        chk("R4 gack waits for busy release", {31'd0, bus_gack}, 0);
      end else begin
        chk("R4 gack on claim edge", {31'd0, bus_gack}, 1);
        chk("R6 as on claim edge", {31'd0, bus_as}, 1);
        chk("R6 ds not yet", {31'd0, bus_ds}, 0);
        chk("R6 address valid", {12'd0, bus_addr}, {12'd0, v.addr});
        chk("R10 direction", {31'd0, bus_rd}, {31'd0, ~v.we});
        chk("R10 output enable", {31'd0, bus_doe}, {31'd0, v.we});
      end
    end
    @(negedge clk); #1;
    bus_grant = 1'b0;
    chk("R6 ds half cycle later", {31'd0, bus_ds}, 1);
    chk("R5 req released", {31'd0, bus_req}, 0);
    if (v.we) chk("R10 write data driven", {16'd0, bus_dout}, {16'd0, v.wdata});
    for (int k = 0; k <= int'(v.waits); k++) begin
      @(posedge clk); #1;
      chk("R7 strobes held", {30'd0, bus_as, bus_ds}, 3);
      if (poke && k == 0) begin
        core_req = 1'b1; core_we = 1'b1; core_addr = 20'h33333;
      end
      if (poke && k == 1) core_req = 1'b0;
      if (k == int'(v.waits)) begin
        bus_ack = 1'b1; bus_din = v.rdat;
      end
    end
    core_req = 1'b0;
    @(posedge clk); #1;
    bus_ack = 1'b0; bus_din = '0;
    if (!v.we) exp_rdata = v.rdat;
    chk("R8 strobes released", {30'd0, bus_as, bus_ds}, 0);
    chk("R8 gack released", {31'd0, bus_gack}, 0);
    chk("R8 read data", {16'd0, core_rdata}, {16'd0, exp_rdata});
    chk("R9 done pulse", {31'd0, core_done}, 1);
    @(posedge clk); #1;
    chk("R9 done single cycle", {31'd0, core_done}, 0);
    chk("R11 address idle", {12'd0, bus_addr}, 0);
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); #1;
        chk("R2 busy request ignored", {31'd0, bus_req}, 0);
        chk("R2 no extra done", {31'd0, core_done}, 0);
      end
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    core_req = 1'b0; core_we = 1'b0; core_addr = '0; core_wdata = '0;
    bus_grant = 1'b0; bus_busy = 1'b0; bus_ack = 1'b0; bus_din = '0;
    exp_rdata = '0;
    repeat (3) @(posedge clk);
    #1;
    idle_outputs("R1 reset state");
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int i = 0; i < NV; i++) txn(VECS[i], 1'b0);

    txn('{1'b0, 20'h4C4C4, 16'h0000, 16'hC0DE, 4'd2, 4'd3}, 1'b1);
    txn('{1'b1, 20'h00002, 16'hFACE, 16'h0000, 4'd0, 4'd0}, 1'b0);

    @(posedge clk); #1;
    core_req = 1'b1; core_we = 1'b0; core_addr = 20'h12345;
    @(posedge clk); #1;
    core_req = 1'b0; bus_grant = 1'b1; bus_busy = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 owned before reset", {31'd0, bus_gack}, 1);
    rst_n = 1'b0;
    #1;
    idle_outputs("R1 reset mid transfer");
    bus_grant = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    idle_outputs("R1 idle after reset release");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule